// File: doc/BRIEF.md
# Single-Lane Structure Store Sequencer

This block carries out a store of one small structure of n elements, with n from 1 to 4. Each element comes from the same lane of a different register in a file of 32 vector registers, each 64 bits wide. The block writes the elements to consecutive byte addresses in memory. The registers are either adjacent to one another or spaced two apart.

A decoded command arrives over a valid/ready handshake. The command carries:
- the element count;
- the element size;
- the first register and the spacing;
- the lane number;
- an optional alignment hint;
- the base address, a writeback mode and an offset.

The block reads each register through a combinational read port. It sends one write per element, and each write is held until memory accepts it. A one-cycle done pulse then reports the updated base address and any error flag.

Before any write, the block screens the command. An encoding outside the legal set raises an illegal-encoding error. A base address that breaks the alignment hint raises an alignment fault. Either error ends the command with no memory traffic and no change to the base. Back-pressure works in both directions. While a command is in flight, `cmd_ready` stays low. While `mem_ready` is low, `mem_valid` and its address, data and enables stay frozen.

Top module: `lane_struct_store`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle, so `cmd_valid` has no effect while a command is in flight or being reported.
- R2: Field encodings are as follows.
  - `cmd_count_m1` holds n-1.
  - `cmd_esize` selects the element size: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits.
  - `cmd_align` selects the hint: 0 for none, 1 for 2 bytes, 2 for 4 bytes, 3 for 8 bytes, 4 for 16 bytes.
  - `cmd_wb` selects the writeback: 0 keeps the base, 1 adds the bytes stored, 2 adds `cmd_offset`.
  - `cmd_spaced`=1 selects a register step of 2; 0 selects a step of 1.
- R3: The command is illegal if any of the following holds:
  - `cmd_esize`=3, `cmd_align`>4 or `cmd_wb`=3;
  - `cmd_spaced`=1 together with 8-bit elements or with n=1;
  - the last register index, first + (n-1)·step, exceeds 31;
  - the lane is not below 64 divided by the element size in bits;
  - the hint is nonzero but not allowed by R4.
- R4: Nonzero hints are allowed only as follows.
  - n=1: 2 bytes for 16-bit elements and 4 bytes for 32-bit elements. No hint is allowed for 8-bit elements.
  - n=2: exactly twice the element size in bytes.
  - n=3: none.
  - n=4: 4 bytes for 8-bit elements, 8 bytes for 16-bit elements, and 8 or 16 bytes for 32-bit elements.
- R5: Consider a command that is legal and carries a nonzero hint. If its base address is not a multiple of the hint, the command raises an alignment fault and issues no memory write.
- R6: A legal, aligned command issues exactly n writes. Write k (0-based) has the following contents:
  - register index: first + k·step;
  - address: base + k·size_bytes;
  - data: that register's lane element, right-justified in `mem_wdata` with zeros above it;
  - `mem_be`: 4'b0001, 4'b0011 or 4'b1111 for 8, 16 or 32 bits. Byte i of the data goes to address `mem_addr`+i.
- R7: Once `mem_valid` is high, it stays high with `mem_addr`, `mem_wdata` and `mem_be` unchanged until a cycle in which `mem_ready` is high.
- R8: `done` pulses for exactly one cycle.
  - For a command that writes, the pulse comes in the cycle after its last accepted write.
  - For a command that errors, the pulse comes in the cycle after acceptance.
  - `err_illegal` and `err_align` are high only together with `done`, and never both at once. An illegal command never reports an alignment fault.
- R9: With `done`, `done_base` gives the new base value.
  - Writeback mode 1: base + n·size_bytes.
  - Writeback mode 2: base + `cmd_offset`.
  - Writeback mode 0, or any error: the base unchanged.
- R10: After reset the block is idle: `cmd_ready`=1, `mem_valid`=0, `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_count_m1 | input | 2 | Element count minus one |
| cmd_esize | input | 2 | Element size code |
| cmd_first_reg | input | 5 | First register index |
| cmd_spaced | input | 1 | Register step of 2 instead of 1 |
| cmd_lane | input | 3 | Lane number within each register |
| cmd_align | input | 3 | Alignment hint code |
| cmd_wb | input | 2 | Writeback mode |
| cmd_base | input | 32 | Base byte address |
| cmd_offset | input | 32 | Offset added in writeback mode 2 |
| rf_addr | output | 5 | Register file read index |
| rf_data | input | 64 | Register file read data, same cycle |
| mem_valid | output | 1 | Memory write offered |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_be | output | 4 | Byte enables |
| done | output | 1 | Completion pulse |
| done_base | output | 32 | Updated base, valid with done |
| err_align | output | 1 | Alignment fault, valid with done |
| err_illegal | output | 1 | Illegal encoding, valid with done |

## Verification
The hardest case to reach is a legal, aligned command whose write is stalled by a low `mem_ready` while a second command is already waiting on `cmd_valid`. That second command must stay unaccepted even through the done cycle. The bench reaches this case by sweeping the full cross of count, size, spacing, hint code (including an out-of-range code), writeback mode, edge register indices and edge lanes. Memory readiness follows a pseudo-random sequence. On every other command, the bench keeps offering a decoy command with a different base and first register for the whole time the first command is busy. Base addresses cycle through all sixteen low-bit patterns, so each hint size is met both aligned and misaligned.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DONE = 2'd2
  } lss_state_e;

  localparam logic [1:0] SZ_B8  = 2'd0;
  localparam logic [1:0] SZ_B16 = 2'd1;
  localparam logic [1:0] SZ_B32 = 2'd2;

  localparam logic [2:0] HINT_NONE = 3'd0;
  localparam logic [2:0] HINT_2B   = 3'd1;
  localparam logic [2:0] HINT_4B   = 3'd2;
  localparam logic [2:0] HINT_8B   = 3'd3;
  localparam logic [2:0] HINT_16B  = 3'd4;

  localparam logic [1:0] WB_KEEP = 2'd0;
  localparam logic [1:0] WB_POST = 2'd1;
  localparam logic [1:0] WB_OFFS = 2'd2;
endpackage

// File: rtl/lss_legal.sv
module lss_legal
  import lss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 32,
  parameter int REG_W  = 64,
  localparam int RIDX_W = $clog2(NREG),
  localparam int LANE_W = $clog2(REG_W/8)
) (
  input  logic [1:0]        count_m1,
  input  logic [1:0]        esize,
  input  logic [RIDX_W-1:0] first_reg,
  input  logic              spaced,
  input  logic [LANE_W-1:0] lane,
  input  logic [2:0]        hint,
  input  logic [1:0]        wb,
  input  logic [ADDR_W-1:0] base,
  output logic              illegal,
  output logic              misalign
);
  logic [RIDX_W+1:0] last_idx;
  logic              hint_ok;
  logic [ADDR_W-1:0] hint_mask;

  // Highest register index the command will read
  assign last_idx = (RIDX_W+2)'(first_reg) + ((RIDX_W+2)'(count_m1) << spaced);

  always_comb begin
    hint_ok = 1'b1;
    if (hint != HINT_NONE) begin
      unique case (count_m1)
        2'd0:    hint_ok = (esize == SZ_B16 && hint == HINT_2B) ||
                           (esize == SZ_B32 && hint == HINT_4B);
        2'd1:    hint_ok = (hint == 3'(esize) + 3'd1);
        2'd2:    hint_ok = 1'b0;
        default: hint_ok = (esize == SZ_B8  && hint == HINT_4B) ||
                           (esize == SZ_B16 && hint == HINT_8B) ||
                           (esize == SZ_B32 && (hint == HINT_8B || hint == HINT_16B));
      endcase
    end
  end

  always_comb begin
    illegal = 1'b0;
    if (esize == 2'd3 || wb == 2'd3 || hint > HINT_16B)
      illegal = 1'b1;
    else begin
      if (spaced && (esize == SZ_B8 || count_m1 == 2'd0)) illegal = 1'b1;
      if (last_idx >= (RIDX_W+2)'(NREG))                   illegal = 1'b1;
      if (int'(lane) >= ((REG_W/8) >> esize))              illegal = 1'b1;
      if (!hint_ok)                                        illegal = 1'b1;
    end
  end

  assign hint_mask = (ADDR_W'(1) << hint) - ADDR_W'(1);
  assign misalign  = !illegal && (hint != HINT_NONE) && ((base & hint_mask) != '0);
endmodule

// File: rtl/lss_lane_pick.sv
module lss_lane_pick #(
  parameter int REG_W  = 64,
  parameter int ELEM_W = 32,
  localparam int LANE_W = $clog2(REG_W/8),
  localparam int SH_W   = $clog2(REG_W),
  localparam int BE_W   = ELEM_W/8
) (
  input  logic [REG_W-1:0]  reg_data,
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        esize,
  output logic [ELEM_W-1:0] elem,
  output logic [BE_W-1:0]   be
);
  logic [SH_W-1:0]  shamt;
  logic [REG_W-1:0] shifted;

  // Bit offset of the lane: lane * 8 * 2^esize
  assign shamt   = SH_W'({lane, 3'b000}) << esize;
  assign shifted = reg_data >> shamt;

  always_comb begin
    unique case (esize)
      2'd0: begin
        elem = ELEM_W'(shifted[7:0]);
        be   = BE_W'(1);
      end
      2'd1: begin
        elem = ELEM_W'(shifted[15:0]);
        be   = BE_W'(3);
      end
      default: begin
        elem = ELEM_W'(shifted[31:0]);
        be   = BE_W'(15);
      end
    endcase
  end
endmodule

// File: rtl/lane_struct_store.sv
module lane_struct_store
  import lss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 32,
  parameter int REG_W  = 64,
  parameter int ELEM_W = 32,
  localparam int RIDX_W = $clog2(NREG),
  localparam int LANE_W = $clog2(REG_W/8),
  localparam int BE_W   = ELEM_W/8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_count_m1,
  input  logic [1:0]        cmd_esize,
  input  logic [RIDX_W-1:0] cmd_first_reg,
  input  logic              cmd_spaced,
  input  logic [LANE_W-1:0] cmd_lane,
  input  logic [2:0]        cmd_align,
  input  logic [1:0]        cmd_wb,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_offset,
  output logic [RIDX_W-1:0] rf_addr,
  input  logic [REG_W-1:0]  rf_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ELEM_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  output logic              done,
  output logic [ADDR_W-1:0] done_base,
  output logic              err_align,
  output logic              err_illegal
);
  lss_state_e        state;
  logic [1:0]        q_count_m1, q_esize, q_wb, idx;
  logic [RIDX_W-1:0] q_first;
  logic              q_spaced, q_ill, q_mis;
  logic [LANE_W-1:0] q_lane;
  logic [ADDR_W-1:0] q_base, q_offset, cur_addr;
  logic              chk_ill, chk_mis, accept, last_beat;
  logic [ADDR_W-1:0] elem_bytes, total_bytes;

  lss_legal #(.ADDR_W(ADDR_W), .NREG(NREG), .REG_W(REG_W)) u_legal (
    .count_m1 (cmd_count_m1),
    .esize    (cmd_esize),
    .first_reg(cmd_first_reg),
    .spaced   (cmd_spaced),
    .lane     (cmd_lane),
    .hint     (cmd_align),
    .wb       (cmd_wb),
    .base     (cmd_base),
    .illegal  (chk_ill),
    .misalign (chk_mis)
  );

  lss_lane_pick #(.REG_W(REG_W), .ELEM_W(ELEM_W)) u_pick (
    .reg_data(rf_data),
    .lane    (q_lane),
    .esize   (q_esize),
    .elem    (mem_wdata),
    .be      (mem_be)
  );

  assign cmd_ready   = (state == ST_IDLE);
  assign accept      = cmd_valid && cmd_ready;
  assign mem_valid   = (state == ST_SEND);
  assign last_beat   = mem_valid && mem_ready && (idx == q_count_m1);
  assign elem_bytes  = ADDR_W'(1) << q_esize;
  assign total_bytes = ADDR_W'({1'b0, q_count_m1} + 3'd1) << q_esize;
  assign rf_addr     = q_first + (RIDX_W'(idx) << q_spaced);
  assign mem_addr    = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      cur_addr   <= '0;
      q_count_m1 <= '0;
      q_esize    <= '0;
      q_wb       <= '0;
      q_first    <= '0;
      q_spaced   <= 1'b0;
      q_lane     <= '0;
      q_base     <= '0;
      q_offset   <= '0;
      q_ill      <= 1'b0;
      q_mis      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          q_count_m1 <= cmd_count_m1;
          q_esize    <= cmd_esize;
          q_wb       <= cmd_wb;
          q_first    <= cmd_first_reg;
          q_spaced   <= cmd_spaced;
          q_lane     <= cmd_lane;
          q_base     <= cmd_base;
          q_offset   <= cmd_offset;
          q_ill      <= chk_ill;
          q_mis      <= chk_mis;
          cur_addr   <= cmd_base;
          idx        <= '0;
          state      <= (chk_ill || chk_mis) ? ST_DONE : ST_SEND;
        end
        ST_SEND: if (mem_ready) begin
          cur_addr <= cur_addr + elem_bytes;
          idx      <= idx + 2'd1;
          if (last_beat) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done        = (state == ST_DONE);
  assign err_illegal = done && q_ill;
  assign err_align   = done && q_mis;

  always_comb begin
    done_base = q_base;
    if (!q_ill && !q_mis) begin
      if (q_wb == WB_POST)      done_base = q_base + total_bytes;
      else if (q_wb == WB_OFFS) done_base = q_base + q_offset;
    end
  end
endmodule

// File: rtl/lane_struct_store_chk.sv
module lane_struct_store_chk #(
  parameter int ADDR_W = 32,
  parameter int ELEM_W = 32,
  localparam int BE_W = ELEM_W/8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ELEM_W-1:0] mem_wdata,
  input logic [BE_W-1:0]   mem_be,
  input logic              done,
  input logic              err_align,
  input logic              err_illegal
);
  logic              have_prev;
  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      next_addr <= '0;
    end else if (done) begin
      have_prev <= 1'b0;
    end else if (mem_valid && mem_ready) begin
      have_prev <= 1'b1;
      next_addr <= mem_addr + ADDR_W'($countones(mem_be));
    end
  end

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || done) |-> !cmd_ready);

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_align || err_illegal) |-> done && $onehot0({err_align, err_illegal}));

  // R6
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be == BE_W'(1) || mem_be == BE_W'(3) || mem_be == BE_W'(15)));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && have_prev |-> mem_addr == next_addr);
endmodule

bind lane_struct_store lane_struct_store_chk #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_be     (mem_be),
  .done       (done),
  .err_align  (err_align),
  .err_illegal(err_illegal)
);

// File: tb/lane_struct_store_tb.sv
module lane_struct_store_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_count_m1 = '0, cmd_esize = '0, cmd_wb = '0;
  logic [4:0]  cmd_first_reg = '0;
  logic        cmd_spaced = 1'b0;
  logic [2:0]  cmd_lane = '0, cmd_align = '0;
  logic [31:0] cmd_base = '0, cmd_offset = '0;
  logic [4:0]  rf_addr;
  logic [63:0] rf_data;
  logic        mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, done_base;
  logic [3:0]  mem_be;
  logic        done, err_align, err_illegal;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  lane_struct_store u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_count_m1(cmd_count_m1), .cmd_esize(cmd_esize), .cmd_first_reg(cmd_first_reg),
    .cmd_spaced(cmd_spaced), .cmd_lane(cmd_lane), .cmd_align(cmd_align), .cmd_wb(cmd_wb),
    .cmd_base(cmd_base), .cmd_offset(cmd_offset), .rf_addr(rf_addr), .rf_data(rf_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .done(done), .done_base(done_base), .err_align(err_align),
    .err_illegal(err_illegal)
  );

  function automatic logic [63:0] regval(input logic [4:0] i);
    return 64'hA5C3_1E87_0F69_D24B ^ ({59'd0, i} * 64'h9E37_79B9_7F4A_7C15) ^ {8{3'b000, i}};
  endfunction

  assign rf_data = regval(rf_addr);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Illegal-encoding rules of R3 with the hint table of R4
  function automatic bit exp_illegal(int nm1, int esz, int first, int sp, int lane, int al, int wb);
    bit ok;
    if (esz == 3 || wb == 3 || al > 4) return 1'b1;
    if (sp == 1 && (esz == 0 || nm1 == 0)) return 1'b1;
    if (first + nm1 * (sp + 1) > 31) return 1'b1;
    if (lane >= (8 >> esz)) return 1'b1;
    if (al == 0) return 1'b0;
    case (nm1)
      0: ok = (esz == 1 && al == 1) || (esz == 2 && al == 2);
      1: ok = (al == esz + 1);
      2: ok = 1'b0;
      default: ok = (esz == 0 && al == 2) || (esz == 1 && al == 3) || (esz == 2 && (al == 3 || al == 4));
    endcase
    return !ok;
  endfunction

  task automatic run_cmd(input int nm1, input int esz, input int first, input int sp,
                         input int lane, input int al, input int wb,
                         input logic [31:0] base, input logic [31:0] off, input bit decoy);
    bit ill, mis, fin;
    int nwr, n, bytes, step;
    logic [31:0] exp_base, eaddr;
    logic [63:0] shifted;
    logic [31:0] edata;
    logic [3:0]  ebe;
    n = nm1 + 1;
    bytes = 1 << esz;
    step = sp + 1;
    ill = exp_illegal(nm1, esz, first, sp, lane, al, wb);
    mis = !ill && al != 0 && ((base & ((32'd1 << al) - 32'd1)) != 0);
    exp_base = base;
    if (!ill && !mis) begin
      if (wb == 1) exp_base = base + 32'(n * bytes);
      else if (wb == 2) exp_base = base + off;
    end
    ebe = (esz == 0) ? 4'h1 : (esz == 1) ? 4'h3 : 4'hF;
    @(negedge clk);
    cmd_count_m1 = 2'(nm1); cmd_esize = 2'(esz); cmd_first_reg = 5'(first);
    cmd_spaced = sp[0]; cmd_lane = 3'(lane); cmd_align = 3'(al); cmd_wb = 2'(wb);
    cmd_base = base; cmd_offset = off; cmd_valid = 1'b1;
    @(negedge clk);
    if (decoy) begin
      // R1: a second command stays offered while the first is busy
      cmd_first_reg = 5'(first + 3);
      cmd_base = base ^ 32'h0000_0100;
    end else
      cmd_valid = 1'b0;
    check(!cmd_ready, "R1 cmd_ready low while busy", {127'd0, cmd_ready}, 128'd0);
    nwr = 0;
    fin = 1'b0;
    for (int t = 0; t < 64 && !fin; t++) begin
      bit rdy;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = lfsr[0] | lfsr[3];
      if (mem_valid && rdy) begin
        // R6: register, address, lane data and enables of write nwr
        shifted = regval(5'(first + nwr * step)) >> (lane * 8 * bytes);
        edata = (esz == 0) ? {24'd0, shifted[7:0]} : (esz == 1) ? {16'd0, shifted[15:0]} : shifted[31:0];
        eaddr = base + 32'(nwr * bytes);
        check(mem_addr == eaddr && mem_wdata == edata && mem_be == ebe && nwr < n && !ill && !mis,
              "R6 write addr/data/be", {mem_addr, mem_wdata, 28'd0, mem_be, 32'(nwr)},
              {eaddr, edata, 28'd0, ebe, 32'(nwr)});
        nwr++;
      end
      if (done) begin
        cmd_valid = 1'b0;
        // R3 R5 R8: flags and R9: writeback value
        check(err_illegal == ill && err_align == mis, "R3/R5 error flags",
              {126'd0, err_illegal, err_align}, {126'd0, ill, mis});
        check(done_base == exp_base, "R9 done_base", {96'd0, done_base}, {96'd0, exp_base});
        check(nwr == ((ill || mis) ? 0 : n), "R8 write count before done",
              128'(nwr), 128'((ill || mis) ? 0 : n));
        fin = 1'b1;
      end
      mem_ready = rdy;
      @(negedge clk);
    end
    mem_ready = 1'b0;
    if (!fin) check(1'b0, "R8 done never seen", 128'd0, 128'd1);
    else check(!done, "R8 done one cycle", {127'd0, done}, 128'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 190000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int iter;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(cmd_ready && !mem_valid && !done, "R10 reset state",
          {125'd0, cmd_ready, mem_valid, done}, {125'd0, 3'b100});
    rst_n = 1'b1;
    iter = 0;
    for (int nm1 = 0; nm1 < 4; nm1++)
      for (int esz = 0; esz < 4; esz++)
        for (int sp = 0; sp < 2; sp++)
          for (int al = 0; al < 6; al++)
            for (int wb = 0; wb < 4; wb++)
              for (int fi = 0; fi < 3; fi++)
                for (int li = 0; li < 3; li++) begin
                  int first, lane, lim;
                  logic [31:0] base;
                  first = (fi == 0) ? 0 : (fi == 1) ? 25 : 31;
                  lim = (esz == 3) ? 1 : (8 >> esz);
                  lane = (li == 0) ? 0 : (li == 1) ? lim - 1 : (lim & 7);
                  base = {iter[15:0], 12'h000, iter[3:0]};
                  // R2 R4: every hint code crossed with every count and size
                  run_cmd(nm1, esz, first, sp, lane, al, wb, base,
                          32'(iter * 119 + 5), iter[0]);
                  iter++;
                end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule